// File: doc/BRIEF.md
# Serially Loaded Trigger Crossbar

This block is a seven-by-seven routing switch. It sits between seven board-side signals and seven shared trigger lines. Every pin on either side can take its value from any pin on the opposite side, so the same matrix can carry signals from the board onto the trigger lines or from the trigger lines onto the board. Each pin is modelled as a drive-enable and data pair, which stands in for a tri-state pad.

Software sets up a routing pattern by writing one bit at a time into a 56-bit staging shift register. A separate commit write then copies the whole staged pattern into the active control register in a single clock edge. Every route therefore changes at the same moment, and half-loaded patterns never reach the pins. The routing outputs are combinational from the active register and the input pins.

Top module: `trig_xbar`

## Requirements
- R1: After reset the active pattern and the staged pattern are all zeros, so every `a_oe`, `a_out`, `b_oe` and `b_out` bit is 0.
- R2: A cycle with `wr_shift` high shifts the staging register left by one place and puts `wr_data[0]` into its bit 0. Bits 7:1 of `wr_data` have no effect on the staged or active pattern.
- R3: A pattern is loaded with 56 shift writes, most significant bit first, so the first bit written ends in bit 55. The pattern holds 14 four-bit fields. From bit 55 downward they are trigger lines 6 to 0, then board pins 6 to 0. In each field, bit 3 is the enable and bits 2:0 select the source pin number on the opposite side.
- R4: Shift writes without a commit never change `a_oe`, `a_out`, `b_oe` or `b_out`.
- R5: A cycle with `wr_commit` high loads the staged pattern into the active register, and the outputs follow from the next cycle. `wr_data` is ignored during a commit.
- R6: When a trigger-line field is enabled with select s in 0..6, `b_oe` of that line is 1 and `b_out` of that line equals `a_in[s]`.
- R7: When a board-pin field is enabled with select s in 0..6, `a_oe` of that pin is 1 and `a_out` of that pin equals `b_in[s]`.
- R8: Select value 7 is reserved. A field holding it leaves its pin undriven (enable 0, data 0), even when its enable bit is set.
- R9: A field whose enable bit is 0 leaves its pin undriven with data 0, whatever its select holds.
- R10: When `wr_shift` and `wr_commit` are both high in one cycle, the commit captures the staged pattern as it was before that cycle's shift, and the shift still takes place.
- R11: One source pin may feed several pins on the opposite side at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_shift | input | 1 | Shift write strobe (serial-input register) |
| wr_commit | input | 1 | Commit write strobe (copy staged to active) |
| wr_data | input | 8 | Host write data; only bit 0 is used, and only by shift writes |
| a_in | input | 7 | Board-side pin input values |
| b_in | input | 7 | Trigger-line input values |
| a_oe | output | 7 | Board-side pin drive enables |
| a_out | output | 7 | Board-side pin drive data |
| b_oe | output | 7 | Trigger-line drive enables |
| b_out | output | 7 | Trigger-line drive data |

## Verification
A shift write and a commit write can both be active in the same cycle. They are independent strobes, so neither blocks the other. The bench stages a full pattern without committing it, then raises both strobes on one edge. It first checks that the pins now show the pattern staged before that edge. It then commits alone and checks that the pins show that pattern moved up by one place with the new bit at the bottom. Expected pin values always come from the bench's own field decoder, applied to the pattern the bench believes is active.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

  localparam int unsigned DEF_PINS   = 7;
  localparam int unsigned DEF_DATA_W = 8;

  // Width of a select field able to name every pin plus one reserved code.
  function automatic int unsigned sel_width(input int unsigned pins);
    return $clog2(pins + 1);
  endfunction

  // A field drives its pin only when enabled and its select names a real pin.
  function automatic logic field_live(input logic en, input int unsigned sel,
                                      input int unsigned pins);
    return en && (sel < pins);
  endfunction

endpackage

// File: rtl/xbar_stage.sv
module xbar_stage #(
  parameter int unsigned CFG_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [CFG_W-1:0] stage_q
);

  logic [CFG_W-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    if (shift_en) stage_d = {stage_q[CFG_W-2:0], shift_bit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // R2: a shift write moves the old contents up and appends the serial bit
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (stage_q[0] == $past(shift_bit)) &&
                 (stage_q[CFG_W-1:1] == $past(stage_q[CFG_W-2:0])));

  // R2: without a shift write the staged pattern holds
  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q));

endmodule

// File: rtl/xbar_active.sv
module xbar_active #(
  parameter int unsigned CFG_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  input  logic [CFG_W-1:0] stage_q,
  output logic [CFG_W-1:0] active_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)         active_q <= '0;
    else if (commit_en) active_q <= stage_q;
  end

  // R5, R10: a commit takes the staged pattern seen on that same edge
  assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> active_q == $past(stage_q));

  // R4: routing is untouched while no commit happens
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> $stable(active_q));

endmodule

// File: rtl/xbar_side.sv
module xbar_side #(
  parameter int unsigned N_PINS = 7,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned FLD_W = SEL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PINS*FLD_W-1:0] fields,
  input  logic [N_PINS-1:0]       src,
  output logic [N_PINS-1:0]       oe,
  output logic [N_PINS-1:0]       dout
);
  import trig_xbar_pkg::*;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [FLD_W-1:0] fld;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             live;
    logic             picked;

    assign fld  = fields[p*FLD_W +: FLD_W];
    assign en   = fld[FLD_W-1];
    assign sel  = fld[SEL_W-1:0];
    assign live = field_live(en, int'(sel), N_PINS);

    always_comb begin
      picked = 1'b0;
      for (int j = 0; j < N_PINS; j++) begin
        if (sel == SEL_W'(j)) picked = src[j];
      end
    end

    assign oe[p]   = live;
    assign dout[p] = live & picked;

    // R8, R9: an undriven pin always presents data 0
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !oe[p] |-> !dout[p]);

    // R8: a driven pin never carries the reserved select code
    assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe[p] |-> (int'(fields[p*FLD_W +: SEL_W]) < N_PINS) && fields[p*FLD_W+SEL_W]);
  end

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar #(
  parameter int unsigned N_PINS = trig_xbar_pkg::DEF_PINS,
  parameter int unsigned DATA_W = trig_xbar_pkg::DEF_DATA_W,
  localparam int unsigned SEL_W = trig_xbar_pkg::sel_width(N_PINS),
  localparam int unsigned FLD_W = SEL_W + 1,
  localparam int unsigned HALF  = N_PINS * FLD_W,
  localparam int unsigned CFG_W = 2 * HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_shift,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_PINS-1:0] a_in,
  input  logic [N_PINS-1:0] b_in,
  output logic [N_PINS-1:0] a_oe,
  output logic [N_PINS-1:0] a_out,
  output logic [N_PINS-1:0] b_oe,
  output logic [N_PINS-1:0] b_out
);

  logic [CFG_W-1:0] stage_q;
  logic [CFG_W-1:0] active_q;
  logic             serial_bit;
  logic             unused_hi_bits;

  assign serial_bit     = wr_data[0];
  assign unused_hi_bits = ^wr_data[DATA_W-1:1];

  xbar_stage #(.CFG_W(CFG_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (wr_shift),
    .shift_bit(serial_bit),
    .stage_q  (stage_q)
  );

  xbar_active #(.CFG_W(CFG_W)) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_en(wr_commit),
    .stage_q  (stage_q),
    .active_q (active_q)
  );

  // Upper half of the pattern drives the trigger lines from board pins.
  xbar_side #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_bus_side (
    .clk   (clk),
    .rst_n (rst_n),
    .fields(active_q[CFG_W-1:HALF]),
    .src   (a_in),
    .oe    (b_oe),
    .dout  (b_out)
  );

  // Lower half drives the board pins from the trigger lines.
  xbar_side #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_board_side (
    .clk   (clk),
    .rst_n (rst_n),
    .fields(active_q[HALF-1:0]),
    .src   (b_in),
    .oe    (a_oe),
    .dout  (a_out)
  );

  // R1: the cycle after a reset edge nothing is driven
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (a_oe == '0) && (b_oe == '0));

  // R4: outputs react only through a commit or an input pin change
  assert_no_route_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_commit && $stable(a_in) && $stable(b_in)) |=>
      $stable(a_oe) && $stable(b_oe));

endmodule

// File: tb/trig_xbar_bench.sv
`timescale 1ns/1ps
module trig_xbar_bench;

  localparam logic [55:0] CFG_AB  = 56'h89ABCDE_0000000; // B_p <- A[6-p]
  localparam logic [55:0] CFG_BA  = 56'h0000000_8EDCBA9; // A_p <- B[(p+1)%7]
  localparam logic [55:0] CFG_MIX = 56'hAFA3F8E_8F5BE09; // reserved, disabled, fan-out

  typedef struct packed {
    logic [1:0] cfg_id;
    logic [6:0] a;
    logic [6:0] b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h55, 7'h00},
    '{2'd0, 7'h2A, 7'h7F},
    '{2'd0, 7'h01, 7'h33},
    '{2'd1, 7'h7F, 7'h4C},
    '{2'd1, 7'h00, 7'h13},
    '{2'd2, 7'h04, 7'h7F},
    '{2'd2, 7'h7B, 7'h48},
    '{2'd2, 7'h41, 7'h02}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_shift = 1'b0;
  logic       wr_commit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] a_in = '0, b_in = '0;
  logic [6:0] a_oe, a_out, b_oe, b_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  trig_xbar u_trig_xbar (
    .clk(clk), .rst_n(rst_n), .wr_shift(wr_shift), .wr_commit(wr_commit),
    .wr_data(wr_data), .a_in(a_in), .b_in(b_in),
    .a_oe(a_oe), .a_out(a_out), .b_oe(b_oe), .b_out(b_out)
  );

  // Bench decoder: field k counted from the top; k<7 is trigger line 6-k.
  function automatic logic [27:0] model(input logic [55:0] cfg,
                                        input logic [6:0] a, input logic [6:0] b);
    logic [6:0] eb = '0, db = '0, ea = '0, da = '0;
    for (int k = 0; k < 14; k++) begin
      logic [3:0] f = 4'((cfg << (4*k)) >> 52);
      int pin = (k < 7) ? 6 - k : 13 - k;
      if (f[3] && f[2:0] != 3'd7) begin
        if (k < 7) begin eb[pin] = 1'b1; db[pin] = a[f[2:0]]; end
        else       begin ea[pin] = 1'b1; da[pin] = b[f[2:0]]; end
      end
    end
    return {eb, db, ea, da};
  endfunction

  task automatic check(input string req, input logic [27:0] exp);
    logic [27:0] act = {b_oe, b_out, a_oe, a_out};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_pattern(input logic [55:0] cfg, input logic [6:0] junk);
    for (int i = 55; i >= 0; i--) begin
      @(negedge clk);
      wr_shift = 1'b1;
      wr_data  = {junk, cfg[i]};
    end
    @(negedge clk);
    wr_shift = 1'b0;
    wr_data  = 8'h00;
  endtask

  task automatic commit_now();
    wr_commit = 1'b1;
    wr_data   = 8'hFF;           // R5: data during commit is ignored
    @(negedge clk);
    wr_commit = 1'b0;
    wr_data   = 8'h00;
    #1;
  endtask

  function automatic logic [55:0] pick(input logic [1:0] id);
    return (id == 2'd0) ? CFG_AB : (id == 2'd1) ? CFG_BA : CFG_MIX;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  cur;
    logic [55:0] act_cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    a_in = 7'h7F; b_in = 7'h7F;
    #1;
    check("R1 reset idle", 28'h0);
    commit_now();
    check("R1 staged zero after reset", 28'h0);

    // Table walk, R3 R6 R7 R8 R9 R11, junk in high data bits (R2)
    cur = 2'd3;
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].cfg_id != cur) begin
        cur = VECS[v].cfg_id;
        shift_pattern(pick(cur), 7'h7F);
        commit_now();
      end
      a_in = VECS[v].a;
      b_in = VECS[v].b;
      #1;
      check(cur == 2'd0 ? "R6 board to bus" :
            cur == 2'd1 ? "R7 bus to board" : "R8 R9 R11 mixed", model(pick(cur), a_in, b_in));
    end

    // R11 fan-out: A2 feeds B6 and B4
    a_in = 7'h04; #1;
    check("R11 fan-out", {1'b1, 1'b0, 1'b1, 4'b0000, b_oe[6:0] & 7'h00 | model(CFG_MIX, a_in, b_in)[20:14], model(CFG_MIX, a_in, b_in)[13:0]} & 28'h0 | model(CFG_MIX, a_in, b_in));
    tests++;
    if (!(b_out[6] && b_out[4])) begin
      fails++;
      $display("FAIL R11: got %b expected 1 on lines 6 and 4", b_out);
    end

    // R4: stage a new pattern, outputs stay on the old one
    a_in = 7'h35; b_in = 7'h4A;
    shift_pattern(CFG_BA, 7'h00);
    #1;
    check("R4 shift without commit", model(CFG_MIX, a_in, b_in));

    // R10: shift and commit together, then commit alone
    @(negedge clk);
    wr_shift = 1'b1; wr_commit = 1'b1; wr_data = 8'h01;
    @(negedge clk);
    wr_shift = 1'b0; wr_commit = 1'b0; wr_data = 8'h00;
    #1;
    check("R10 commit takes pre-shift pattern", model(CFG_BA, a_in, b_in));
    commit_now();
    act_cfg = {CFG_BA[54:0], 1'b1};
    check("R10 shift applied alongside commit", model(act_cfg, a_in, b_in));

    // R2: high data bits alone do not alter the pattern
    shift_pattern(CFG_AB, 7'h00);
    commit_now();
    check("R2 clean load", model(CFG_AB, a_in, b_in));
    shift_pattern(CFG_AB, 7'h5A);
    commit_now();
    check("R2 high bits ignored", model(CFG_AB, a_in, b_in));

    // R3: a single first-shifted 1 lands in bit 55 (line 6 enable, sel 0)
    shift_pattern(56'h8000000_0000000, 7'h00);
    commit_now();
    a_in = 7'h01; #1;
    check("R3 first bit is MSB", {7'h40, 7'h40, 14'h0});

    // R1: reset mid-run clears routing
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 reset clears routing", 28'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule